// File: doc/BRIEF.md
# Arithmetic Exception Masked-Response Unit

This unit sits after the extended-precision arithmetic datapath of a floating-point core. When the datapath finds an exceptional condition, it hands over the provisional result and a condition code. The result arrives as a sign, a 16-bit biased exponent that may lie outside the storable range, and a 64-bit significand. The unit also takes the current stack-top pointer, the relative destination register and four mask bits from the control word. From these it decides the architectural response. A masked condition gets a substituted default value: infinity, zero, the quiet NaN or the denormalised value. An unmasked overflow or underflow keeps its value, with the exponent moved back into range by a fixed offset. Any other unmasked condition leaves the destination untouched.

One cycle after a valid input, the unit presents a single registered bundle. The bundle holds a register write (absolute index, 80-bit value and class tag), any stack-top adjustment, and the exception requests for the status register unit. The requests include the precision request that a masked overflow or underflow chains behind its primary condition, and the set or clear action on condition bit C1. Rounding and the storage of the status word are handled by other units.

Top module: `exc_mask_resp`

## Requirements
- R1: While rst_n is low at a clock edge, every output goes to zero after that edge: out_valid, wr_en, wr_idx, wr_data, wr_tag, top_wr, top_out, req, c1_set, c1_clr and fault.
- R2: The response to a valid input appears on the outputs after the next rising edge, with out_valid high for that cycle. When in_valid is low, out_valid, wr_en, top_wr, req, c1_set, c1_clr and fault are all low after the next edge. The request bits are: req[0] invalid, req[1] zero-divide, req[2] overflow, req[3] underflow, req[4] precision, req[5] stack fault. The mask bits are: mask_in[0] invalid, [1] zero-divide, [2] overflow, [3] underflow, where 1 means masked. Tags are 0 valid, 1 zero, 2 special. wr_data is {sign, 15-bit exponent field, 64-bit significand}.
- R3: Condition code 1 (overflow) with overflow masked writes infinity with the input sign (exponent field 0x7FFF, significand 0x8000_0000_0000_0000) and tag special. It requests overflow and precision, asserts c1_set, and leaves fault low.
- R4: Condition code 1 with overflow unmasked writes the input sign and significand with an exponent field equal to the low 15 bits of (exp_in − 24576), tag valid. It requests overflow only and asserts fault.
- R5: Condition code 2 (underflow) with underflow unmasked writes the input sign and significand with an exponent field equal to the low 15 bits of (exp_in + 24576 + 16383), tag valid. It requests underflow only and asserts fault.
- R6: Condition code 2 with underflow masked requests underflow and precision, and leaves fault low. If exp_in read as a signed number is −63 or less, it writes a zero with the input sign, uses tag zero and asserts c1_clr. Otherwise it writes the input sign and significand with exponent field 0, tag special.
- R7: Condition code 3 (zero-divide) always requests zero-divide. If masked, it writes infinity with the input sign, tag special. If unmasked, it writes nothing and asserts fault.
- R8: Condition code 0 (invalid) always requests invalid. If masked, it writes the quiet NaN (sign 1, exponent field 0x7FFF, significand 0xC000_0000_0000_0000), tag special. If unmasked, it writes nothing and asserts fault.
- R9: Condition code 4 (stack overflow) requests invalid and stack fault and asserts c1_set. With invalid masked, it sets top_out to top_in − 1 modulo 8 with top_wr high, and writes the quiet NaN to that new top. With invalid unmasked, it writes nothing, keeps top_out equal to top_in and asserts fault.
- R10: Condition codes 5 (stack underflow) and 6 (stack underflow with pop) request invalid and stack fault and assert c1_clr. With invalid masked, they write the quiet NaN to register (top_in + dst_in) modulo 8, and code 6 also sets top_out to top_in + 1 modulo 8 with top_wr high. With invalid unmasked, they write nothing and assert fault.
- R11: For every non-stack write, wr_idx is (top_in + dst_in) modulo 8. top_out equals top_in whenever top_wr is low.
- R12: Condition code 7 is reserved. It gives out_valid high but writes nothing, adjusts nothing, makes no requests and leaves fault low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A condition is presented this cycle |
| cond_in | input | 3 | Condition code (0 invalid, 1 overflow, 2 underflow, 3 zero-divide, 4 stack overflow, 5 stack underflow, 6 stack underflow with pop) |
| mask_in | input | 4 | Control-word masks: invalid, zero-divide, overflow, underflow |
| sign_in | input | 1 | Sign of the provisional result |
| exp_in | input | 16 | Biased exponent of the provisional result, may be out of range |
| sig_in | input | 64 | Significand of the provisional result |
| top_in | input | 3 | Current stack-top pointer |
| dst_in | input | 3 | Destination register relative to the top |
| out_valid | output | 1 | Response bundle valid |
| wr_en | output | 1 | Write wr_data into register wr_idx |
| wr_idx | output | 3 | Absolute register index to write |
| wr_data | output | 80 | Value to write |
| wr_tag | output | 2 | Class tag of the written value |
| top_wr | output | 1 | Stack-top pointer must be updated |
| top_out | output | 3 | New stack-top pointer |
| req | output | 6 | Exception requests to the status unit |
| c1_set | output | 1 | Set condition bit C1 |
| c1_clr | output | 1 | Clear condition bit C1 |
| fault | output | 1 | The primary condition is unmasked |

## Verification
The hardest case to reach is the boundary of the masked underflow flush. A random 16-bit exponent lands on −63 or −62 far too rarely, and the choice between flushing and keeping the denormal changes the value, the tag and the C1 action at once. The bench drives those two exponents directly and biases part of the random underflow stimulus into a narrow window around the threshold. A second set of hard cases is the pointer wrap: a stack overflow at top 0, a pop at top 7, and a write index that wraps when the destination offset carries past 7. Directed cases cover all three, and random top and offset values cover them again.

// File: rtl/exc_resp_pkg.sv
// Package: shared condition codes, tag codes, request and mask bit positions
// for the masked-response unit. Assumes 3-bit condition codes and 2-bit tags.
package exc_resp_pkg;
    typedef enum logic [2:0] {
        COND_INVALID       = 3'd0,
        COND_OVERFLOW      = 3'd1,
        COND_UNDERFLOW     = 3'd2,
        COND_ZERODIV       = 3'd3,
        COND_STK_OVER      = 3'd4,
        COND_STK_UNDER     = 3'd5,
        COND_STK_UNDER_POP = 3'd6,
        COND_RESERVED      = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'd0,
        TAG_ZERO    = 2'd1,
        TAG_SPECIAL = 2'd2,
        TAG_EMPTY   = 2'd3
    } tag_e;

    localparam int REQ_W   = 6;
    localparam int RQ_INV  = 0;
    localparam int RQ_ZDIV = 1;
    localparam int RQ_OVF  = 2;
    localparam int RQ_UNF  = 3;
    localparam int RQ_PREC = 4;
    localparam int RQ_STK  = 5;

    localparam int MASK_W   = 4;
    localparam int MSK_INV  = 0;
    localparam int MSK_ZDIV = 1;
    localparam int MSK_OVF  = 2;
    localparam int MSK_UNF  = 3;

    typedef struct packed {
        logic [REQ_W-1:0] req;
        logic             c1_set;
        logic             c1_clr;
        logic             fault;
    } req_bundle_t;
endpackage

// File: rtl/exc_value_gen.sv
// Module: exc_value_gen
// Picks the value and class tag written for a condition: default substitutes
// for masked cases, re-biased exponent for unmasked overflow/underflow.
// Assumes EXP_W-bit biased exponent input; stored field is EXP_W-1 bits.
module exc_value_gen
    import exc_resp_pkg::*;
#(
    parameter int EXP_W      = 16,
    parameter int SIG_W      = 64,
    parameter int FLUSH_DIST = 63
) (
    input  cond_e                  cond,
    input  logic [MASK_W-1:0]      mask,
    input  logic                   sign,
    input  logic [EXP_W-1:0]       exp,
    input  logic [SIG_W-1:0]       sig,
    output logic                   wr_en,
    output logic [EXP_W+SIG_W-1:0] data,
    output tag_e                   tag
);
    localparam int EF_W = EXP_W - 1;
    localparam logic [EXP_W-1:0] REBIAS   = EXP_W'(3) << (EXP_W - 3);
    localparam logic [EXP_W-1:0] EXT_BIAS = (EXP_W'(1) << (EXP_W - 2)) - EXP_W'(1);
    localparam logic signed [EXP_W-1:0] FLUSH_LIM = EXP_W'(-FLUSH_DIST);
    localparam logic [EF_W-1:0]  EF_ONES  = '1;
    localparam logic [EF_W-1:0]  EF_ZERO  = '0;
    localparam logic [SIG_W-1:0] SIG_INF  = {1'b1, {(SIG_W-1){1'b0}}};
    localparam logic [SIG_W-1:0] SIG_QNAN = {2'b11, {(SIG_W-2){1'b0}}};

    logic [EXP_W-1:0] ovf_exp;
    logic [EXP_W-1:0] unf_exp;
    logic             flush;

    // Exponent re-bias paths and the flush-to-zero threshold compare.
    always_comb begin
        ovf_exp = exp - REBIAS;
        unf_exp = exp + REBIAS + EXT_BIAS;
        flush   = ($signed(exp) <= FLUSH_LIM);
    end

    // Value and tag selection per condition and mask.
    always_comb begin
        wr_en = 1'b0;
        data  = {1'b1, EF_ONES, SIG_QNAN};
        tag   = TAG_SPECIAL;
        unique case (cond)
            COND_OVERFLOW: begin
                wr_en = 1'b1;
                if (mask[MSK_OVF]) begin
                    data = {sign, EF_ONES, SIG_INF};
                end else begin
                    data = {sign, ovf_exp[EF_W-1:0], sig};
                    tag  = TAG_VALID;
                end
            end
            COND_UNDERFLOW: begin
                wr_en = 1'b1;
                if (!mask[MSK_UNF]) begin
                    data = {sign, unf_exp[EF_W-1:0], sig};
                    tag  = TAG_VALID;
                end else if (flush) begin
                    data = {sign, EF_ZERO, {SIG_W{1'b0}}};
                    tag  = TAG_ZERO;
                end else begin
                    data = {sign, EF_ZERO, sig};
                end
            end
            COND_ZERODIV: begin
                wr_en = mask[MSK_ZDIV];
                data  = {sign, EF_ONES, SIG_INF};
            end
            COND_INVALID, COND_STK_OVER, COND_STK_UNDER, COND_STK_UNDER_POP: begin
                wr_en = mask[MSK_INV];
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exc_stack_ctl.sv
// Module: exc_stack_ctl
// Computes the absolute write index and any stack-top adjustment. Assumes
// a power-of-two register stack so the pointer wraps naturally.
module exc_stack_ctl
    import exc_resp_pkg::*;
#(
    parameter int TOP_W = 3
) (
    input  cond_e            cond,
    input  logic             inv_masked,
    input  logic [TOP_W-1:0] top,
    input  logic [TOP_W-1:0] dst,
    output logic [TOP_W-1:0] wr_idx,
    output logic [TOP_W-1:0] top_new,
    output logic             top_wr
);
    logic [TOP_W-1:0] top_dec;
    logic [TOP_W-1:0] top_inc;
    logic [TOP_W-1:0] rel_idx;

    // Modular pointer arithmetic.
    always_comb begin
        top_dec = top - TOP_W'(1);
        top_inc = top + TOP_W'(1);
        rel_idx = top + dst;
    end

    // Index and top selection per condition.
    always_comb begin
        wr_idx  = rel_idx;
        top_new = top;
        top_wr  = 1'b0;
        if (cond == COND_STK_OVER) begin
            wr_idx = top_dec;
            if (inv_masked) begin
                top_new = top_dec;
                top_wr  = 1'b1;
            end
        end else if (cond == COND_STK_UNDER_POP && inv_masked) begin
            top_new = top_inc;
            top_wr  = 1'b1;
        end
    end
endmodule

// File: rtl/exc_req_gen.sv
// Module: exc_req_gen
// Builds the exception request bundle: primary request, chained precision
// request for masked overflow/underflow, C1 action and the unmasked fault.
module exc_req_gen
    import exc_resp_pkg::*;
(
    input  cond_e             cond,
    input  logic [MASK_W-1:0] mask,
    output req_bundle_t       bundle
);
    // Request decode per condition.
    always_comb begin
        bundle = '0;
        unique case (cond)
            COND_INVALID: begin
                bundle.req[RQ_INV] = 1'b1;
                bundle.fault       = !mask[MSK_INV];
            end
            COND_OVERFLOW: begin
                bundle.req[RQ_OVF]  = 1'b1;
                bundle.req[RQ_PREC] = mask[MSK_OVF];
                bundle.c1_set       = mask[MSK_OVF];
                bundle.fault        = !mask[MSK_OVF];
            end
            COND_UNDERFLOW: begin
                bundle.req[RQ_UNF]  = 1'b1;
                bundle.req[RQ_PREC] = mask[MSK_UNF];
                bundle.fault        = !mask[MSK_UNF];
            end
            COND_ZERODIV: begin
                bundle.req[RQ_ZDIV] = 1'b1;
                bundle.fault        = !mask[MSK_ZDIV];
            end
            COND_STK_OVER: begin
                bundle.req[RQ_INV] = 1'b1;
                bundle.req[RQ_STK] = 1'b1;
                bundle.c1_set      = 1'b1;
                bundle.fault       = !mask[MSK_INV];
            end
            COND_STK_UNDER, COND_STK_UNDER_POP: begin
                bundle.req[RQ_INV] = 1'b1;
                bundle.req[RQ_STK] = 1'b1;
                bundle.c1_clr      = 1'b1;
                bundle.fault       = !mask[MSK_INV];
            end
            default: bundle = '0;
        endcase
    end
endmodule

// File: rtl/exc_mask_resp.sv
// Module: exc_mask_resp (top)
// Registers the one-cycle response bundle built from the value, stack and
// request sub-blocks. Assumes one condition per valid cycle; the C1 flush
// clear for masked underflow is merged here from the value path's tag.
module exc_mask_resp
    import exc_resp_pkg::*;
#(
    parameter int EXP_W      = 16,
    parameter int SIG_W      = 64,
    parameter int TOP_W      = 3,
    parameter int FLUSH_DIST = 63
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2:0]             cond_in,
    input  logic [3:0]             mask_in,
    input  logic                   sign_in,
    input  logic [EXP_W-1:0]       exp_in,
    input  logic [SIG_W-1:0]       sig_in,
    input  logic [TOP_W-1:0]       top_in,
    input  logic [TOP_W-1:0]       dst_in,
    output logic                   out_valid,
    output logic                   wr_en,
    output logic [TOP_W-1:0]       wr_idx,
    output logic [EXP_W+SIG_W-1:0] wr_data,
    output logic [1:0]             wr_tag,
    output logic                   top_wr,
    output logic [TOP_W-1:0]       top_out,
    output logic [5:0]             req,
    output logic                   c1_set,
    output logic                   c1_clr,
    output logic                   fault
);
    localparam int DATA_W = EXP_W + SIG_W;

    cond_e                cond;
    logic                 n_wr_en;
    logic [DATA_W-1:0]    n_data;
    tag_e                 n_tag;
    logic [TOP_W-1:0]     n_idx;
    logic [TOP_W-1:0]     n_top;
    logic                 n_top_wr;
    req_bundle_t          n_req;

    assign cond = cond_e'(cond_in);

    exc_value_gen #(.EXP_W(EXP_W), .SIG_W(SIG_W), .FLUSH_DIST(FLUSH_DIST)) u_value (
        .cond(cond), .mask(mask_in), .sign(sign_in), .exp(exp_in), .sig(sig_in),
        .wr_en(n_wr_en), .data(n_data), .tag(n_tag)
    );

    exc_stack_ctl #(.TOP_W(TOP_W)) u_stack (
        .cond(cond), .inv_masked(mask_in[MSK_INV]), .top(top_in), .dst(dst_in),
        .wr_idx(n_idx), .top_new(n_top), .top_wr(n_top_wr)
    );

    exc_req_gen u_req (.cond(cond), .mask(mask_in), .bundle(n_req));

    // Response bundle register; strobes clear on idle cycles, data holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            wr_tag    <= 2'd0;
            top_wr    <= 1'b0;
            top_out   <= '0;
            req       <= '0;
            c1_set    <= 1'b0;
            c1_clr    <= 1'b0;
            fault     <= 1'b0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            wr_en     <= n_wr_en;
            wr_idx    <= n_idx;
            wr_data   <= n_data;
            wr_tag    <= n_tag;
            top_wr    <= n_top_wr;
            top_out   <= n_top;
            req       <= n_req.req;
            c1_set    <= n_req.c1_set;
            c1_clr    <= n_req.c1_clr | (cond == COND_UNDERFLOW && n_tag == TAG_ZERO);
            fault     <= n_req.fault;
        end else begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            top_wr    <= 1'b0;
            req       <= '0;
            c1_set    <= 1'b0;
            c1_clr    <= 1'b0;
            fault     <= 1'b0;
        end
    end

    // R2: idle cycles carry no write, no request and no fault.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (req == '0 && !wr_en && !top_wr && !fault));

    // R3: masked overflow gives a special tag with chained precision and C1 set.
    p_mask_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_in == 3'd1 && mask_in[MSK_OVF]) |=>
        (wr_en && wr_tag == 2'd2 && req[RQ_PREC] && req[RQ_OVF] && c1_set && !fault));

    // R4: unmasked overflow keeps the significand and raises overflow only.
    p_unmask_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_in == 3'd1 && !mask_in[MSK_OVF]) |=>
        (fault && req == 6'b000100 && wr_data[SIG_W-1:0] == $past(sig_in)));

    // R7: zero-divide writes exactly when masked.
    p_zdiv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_in == 3'd3) |=> (req[RQ_ZDIV] && wr_en == $past(mask_in[MSK_ZDIV])));

    // R9: masked stack overflow moves the top down by one.
    p_stk_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_in == 3'd4 && mask_in[MSK_INV]) |=>
        (top_wr && top_out == $past(top_in) - TOP_W'(1) && wr_idx == top_out));

    // R11: top unchanged without an adjustment; C1 never both set and cleared.
    p_top_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_in != 3'd4 && cond_in != 3'd6) |=> (!top_wr && top_out == $past(top_in)));

    p_c1_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(c1_set && c1_clr));
endmodule

// File: tb/exc_mask_resp_bench.sv
// Bench: fixed-seed random and directed stimulus against a reference model.
module exc_mask_resp_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  cond_in;
    logic [3:0]  mask_in;
    logic        sign_in;
    logic [15:0] exp_in;
    logic [63:0] sig_in;
    logic [2:0]  top_in, dst_in;
    logic        out_valid, wr_en, top_wr, c1_set, c1_clr, fault;
    logic [2:0]  wr_idx, top_out;
    logic [79:0] wr_data;
    logic [1:0]  wr_tag;
    logic [5:0]  req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        wr_en;
        logic [2:0]  idx;
        logic [79:0] data;
        logic [1:0]  tag;
        logic        top_wr;
        logic [2:0]  top;
        logic [5:0]  req;
        logic        c1s, c1c, fault;
    } exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_mask_resp u_exc_mask_resp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_in(cond_in),
        .mask_in(mask_in), .sign_in(sign_in), .exp_in(exp_in), .sig_in(sig_in),
        .top_in(top_in), .dst_in(dst_in), .out_valid(out_valid), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_tag(wr_tag), .top_wr(top_wr),
        .top_out(top_out), .req(req), .c1_set(c1_set), .c1_clr(c1_clr), .fault(fault)
    );

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R8";  3'd1: return "R3/R4"; 3'd2: return "R5/R6";
            3'd3: return "R7";  3'd4: return "R9";    3'd5, 3'd6: return "R10";
            default: return "R12";
        endcase
    endfunction

    function automatic exp_t model(input logic [2:0] c, input logic [3:0] m, input logic s,
                                   input logic [15:0] e, input logic [63:0] g,
                                   input logic [2:0] t, input logic [2:0] d);
        exp_t x;
        logic [15:0] adj;
        logic [79:0] qnan;
        logic [79:0] inf;
        qnan = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};
        inf  = {s, 15'h7FFF, 64'h8000_0000_0000_0000};
        x = '0;
        x.top = t;
        x.idx = t + d;
        x.tag = 2'd2;
        case (c)
            3'd0: begin x.req = 6'b000001; x.fault = !m[0]; x.wr_en = m[0]; x.data = qnan; end
            3'd1: begin
                x.wr_en = 1'b1;
                if (m[2]) begin x.req = 6'b010100; x.c1s = 1'b1; x.data = inf; end
                else begin
                    adj = e - 16'd24576;
                    x.req = 6'b000100; x.fault = 1'b1; x.tag = 2'd0; x.data = {s, adj[14:0], g};
                end
            end
            3'd2: begin
                x.wr_en = 1'b1;
                if (!m[3]) begin
                    adj = e + 16'd24576 + 16'd16383;
                    x.req = 6'b001000; x.fault = 1'b1; x.tag = 2'd0; x.data = {s, adj[14:0], g};
                end else begin
                    x.req = 6'b011000;
                    if ($signed(e) <= -16'sd63) begin
                        x.data = {s, 79'd0}; x.tag = 2'd1; x.c1c = 1'b1;
                    end else x.data = {s, 15'd0, g};
                end
            end
            3'd3: begin x.req = 6'b000010; x.fault = !m[1]; x.wr_en = m[1]; x.data = inf; end
            3'd4: begin
                x.req = 6'b100001; x.c1s = 1'b1; x.fault = !m[0]; x.wr_en = m[0];
                x.data = qnan; x.idx = t - 3'd1;
                if (m[0]) begin x.top_wr = 1'b1; x.top = t - 3'd1; end
            end
            3'd5, 3'd6: begin
                x.req = 6'b100001; x.c1c = 1'b1; x.fault = !m[0]; x.wr_en = m[0]; x.data = qnan;
                if (m[0] && c == 3'd6) begin x.top_wr = 1'b1; x.top = t + 3'd1; end
            end
            default: ;
        endcase
        return x;
    endfunction

    task automatic check(input string r, input logic [127:0] act, input logic [127:0] expv,
                         input string what);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", r, what, act, expv);
        end
    endtask

    task automatic apply(input logic [2:0] c, input logic [3:0] m, input logic s,
                         input logic [15:0] e, input logic [63:0] g,
                         input logic [2:0] t, input logic [2:0] d);
        exp_t x;
        string r;
        x = model(c, m, s, e, g, t, d);
        r = req_of(c);
        in_valid = 1'b1; cond_in = c; mask_in = m; sign_in = s;
        exp_in = e; sig_in = g; top_in = t; dst_in = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({r, "/R2"}, 128'(out_valid), 128'd1, "out_valid");
        check(r, 128'(wr_en), 128'(x.wr_en), "wr_en");
        check({r, "/R11"}, 128'({top_wr, top_out}), 128'({x.top_wr, x.top}), "top");
        check(r, 128'({req, c1_set, c1_clr, fault}), 128'({x.req, x.c1s, x.c1c, x.fault}), "requests");
        if (x.wr_en) begin
            check(r, 128'({wr_data, wr_tag}), 128'({x.data, x.tag}), "data/tag");
            check({r, "/R11"}, 128'(wr_idx), 128'(x.idx), "wr_idx");
        end
    endtask

    task automatic idle_check();
        @(posedge clk);
        @(negedge clk);
        check("R2", 128'({out_valid, wr_en, top_wr, req, c1_set, c1_clr, fault}), 128'd0, "idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b1; cond_in = 3'd1; mask_in = 4'hF; sign_in = 1'b1;
        exp_in = 16'hFFFF; sig_in = '1; top_in = 3'd5; dst_in = 3'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 128'({out_valid, wr_en, wr_idx, wr_data, wr_tag, top_wr, top_out, req,
                          c1_set, c1_clr, fault}), 128'd0, "reset");
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle_check();

        // Directed corner cases.
        apply(3'd1, 4'hF, 1'b1, 16'h8000, 64'h1234, 3'd0, 3'd0);         // R3
        apply(3'd1, 4'h0, 1'b0, 16'h8005, 64'hDEAD_BEEF, 3'd1, 3'd2);    // R4
        apply(3'd2, 4'h0, 1'b1, 16'hFFF0, 64'hABCD, 3'd2, 3'd3);         // R5
        apply(3'd2, 4'h8, 1'b1, 16'hFFC1, 64'h0F0F, 3'd3, 3'd0);         // R6 exp -63 flush
        apply(3'd2, 4'h8, 1'b0, 16'hFFC2, 64'h0F0F, 3'd3, 3'd0);         // R6 exp -62 keep
        apply(3'd3, 4'h2, 1'b1, 16'h1, 64'h1, 3'd4, 3'd1);               // R7 masked
        apply(3'd3, 4'h0, 1'b0, 16'h1, 64'h1, 3'd4, 3'd1);               // R7 unmasked
        apply(3'd0, 4'h1, 1'b0, 16'h1, 64'h1, 3'd7, 3'd1);               // R8, R11 idx wrap
        apply(3'd0, 4'h0, 1'b0, 16'h1, 64'h1, 3'd7, 3'd1);               // R8 unmasked
        apply(3'd4, 4'h1, 1'b0, 16'h0, 64'h0, 3'd0, 3'd0);               // R9 top wrap 0->7
        apply(3'd4, 4'h0, 1'b0, 16'h0, 64'h0, 3'd0, 3'd0);               // R9 unmasked
        apply(3'd6, 4'h1, 1'b0, 16'h0, 64'h0, 3'd7, 3'd3);               // R10 pop wrap 7->0
        apply(3'd5, 4'h1, 1'b0, 16'h0, 64'h0, 3'd6, 3'd4);               // R10
        apply(3'd7, 4'hF, 1'b1, 16'h7FFF, 64'h5, 3'd2, 3'd2);            // R12 reserved
        idle_check();

        // Random stimulus, part of underflow biased near the flush threshold.
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  c;
            logic [15:0] e;
            c = 3'($urandom % 8);
            e = 16'($urandom);
            if (c == 3'd2 && ($urandom % 2) == 0) e = 16'(-70 + int'($urandom % 16));
            apply(c, 4'($urandom), 1'($urandom), e, {32'($urandom), 32'($urandom)},
                  3'($urandom), 3'($urandom));
            if (($urandom % 8) == 0) idle_check();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule